// File: doc/BRIEF.md
# Grouped External Interrupt Request Unit

This block collects events from several groups of input pins and raises one interrupt request per group, each group feeding its own interrupt vector. Any pin can be enabled as a source. Every enabled pin in a group is checked against that group's sensitivity setting. The per-pin results are ORed together, and the result sets a request latch for the group.

Software cannot read or write the request latch. It drops by itself when the CPU fetches the matching vector, which shows up here as a one-cycle acknowledge on that vector. The only way software can throw away an unwanted pending request is to write a new value into that group's sensitivity field. Pins are synchronised with two flops, and edges are found by comparing each synchronised sample with the one from the cycle before.

Top module: `eirq_unit`

## Requirements
- R1: After synchronous reset every request output is 0 and every sensitivity field is 00.
- R2: A pin whose enable bit is 0 never causes a request, in any sensitivity mode.
- R3: Sensitivity 01 (rising only): a low-to-high transition on an enabled pin sets the group's request, and a high-to-low transition does not.
- R4: Sensitivity 10 (falling only): a high-to-low transition on an enabled pin sets the request, and a low-to-high transition does not.
- R5: Sensitivity 11 (both edges): either transition on an enabled pin sets the request.
- R6: Sensitivity 00 (falling edge plus low level): the request is set while any enabled pin of the group is low. An acknowledge given while such a pin is still low leaves the request set.
- R7: Pin v*PINS_PER_VEC+i belongs to vector v. An event on any enabled pin of a group sets only that group's request, and several pins of one group are ORed together.
- R8: A set request stays high until the cycle after its vector acknowledge. If no new event is detected in that cycle, the request is 0 in the following cycle.
- R9: When a new event and the acknowledge for the same vector arrive in the same cycle, the request stays set.
- R10: A sensitivity write (field bits [2v+1:2v] for vector v) that changes a vector's field clears that vector's pending request in the next cycle. This clear takes priority over new events. A write that leaves the field unchanged has no effect on the request.
- R11: A pin change applied between clock edges shows on the request output after exactly three rising clock edges: two synchroniser stages and the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_VEC*PINS_PER_VEC | Asynchronous pin levels, grouped by vector |
| pin_irq_en_i | input | NUM_VEC*PINS_PER_VEC | Per-pin interrupt enable |
| sens_we_i | input | 1 | Sensitivity register write strobe |
| sens_wdata_i | input | 2*NUM_VEC | New sensitivity fields, 2 bits per vector |
| vec_ack_i | input | NUM_VEC | Vector fetch acknowledge, one bit per vector |
| irq_o | output | NUM_VEC | Registered interrupt request per vector |

## Verification
A fault in the synchroniser's history flop shows up as a spurious or missing edge. That error reaches the request output after the usual three-edge latency, or shows as the request appearing one cycle early or late. A wrong priority in the request latch is visible in the single cycle after an acknowledge, a coincident event, or a sensitivity rewrite. In that cycle the output either drops when it should hold, or holds when it should drop. A cross-wired group or a lost enable mask shows as a request on the wrong vector within three cycles of a pin change.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  typedef enum logic [1:0] {
    SENS_LOW_FALL = 2'b00,
    SENS_RISE     = 2'b01,
    SENS_FALL     = 2'b10,
    SENS_BOTH     = 2'b11
  } sens_e;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, sync_q, hist_q;

  // Reset to the idle-high level so that release from reset looks like no edge.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      meta_q <= '1;
      sync_q <= '1;
      hist_q <= '1;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign cur_o  = sync_q;
  assign prev_o = hist_q;
endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
  import eirq_pkg::*;
#(
  parameter int PP = 4
) (
  input  logic [PP-1:0] cur_i,
  input  logic [PP-1:0] prev_i,
  input  logic [PP-1:0] en_i,
  input  sens_e         mode_i,
  output logic          hit_o
);
  logic [PP-1:0] rise_w, fall_w, per_pin_w;

  assign rise_w = cur_i & ~prev_i;
  assign fall_w = ~cur_i & prev_i;

  always_comb begin
    unique case (mode_i)
      SENS_LOW_FALL: per_pin_w = ~cur_i;
      SENS_RISE:     per_pin_w = rise_w;
      SENS_FALL:     per_pin_w = fall_w;
      default:       per_pin_w = rise_w | fall_w;
    endcase
  end

  assign hit_o = |(per_pin_w & en_i);
endmodule

// File: rtl/eirq_latch.sv
module eirq_latch (
  input  logic clk_i,
  input  logic rst_i,
  input  logic hit_i,
  input  logic ack_i,
  input  logic drop_i,
  output logic req_o
);
  logic req_q;

  // Priority: sensitivity rewrite, then new event, then acknowledge.
  always_ff @(posedge clk_i) begin
    if (rst_i)       req_q <= 1'b0;
    else if (drop_i) req_q <= 1'b0;
    else if (hit_i)  req_q <= 1'b1;
    else if (ack_i)  req_q <= 1'b0;
  end

  assign req_o = req_q;
endmodule

// File: rtl/eirq_unit.sv
module eirq_unit
  import eirq_pkg::*;
#(
  parameter int NUM_VEC      = 2,
  parameter int PINS_PER_VEC = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_i,
  input  logic [NUM_VEC*PINS_PER_VEC-1:0] pin_i,
  input  logic [NUM_VEC*PINS_PER_VEC-1:0] pin_irq_en_i,
  input  logic                            sens_we_i,
  input  logic [2*NUM_VEC-1:0]            sens_wdata_i,
  input  logic [NUM_VEC-1:0]              vec_ack_i,
  output logic [NUM_VEC-1:0]              irq_o
);
  localparam int NPINS = NUM_VEC * PINS_PER_VEC;

  logic [NPINS-1:0]     cur_w, prev_w;
  logic [2*NUM_VEC-1:0] sens_q;
  logic [NUM_VEC-1:0]   hit_w, drop_w;

  eirq_sync #(.W(NPINS)) u_sync (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .async_i(pin_i),
    .cur_o  (cur_w),
    .prev_o (prev_w)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i)          sens_q <= '0;
    else if (sens_we_i) sens_q <= sens_wdata_i;
  end

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    assign drop_w[v] = sens_we_i &&
                       (sens_wdata_i[2*v +: 2] != sens_q[2*v +: 2]);

    eirq_detect #(.PP(PINS_PER_VEC)) u_det (
      .cur_i (cur_w[v*PINS_PER_VEC +: PINS_PER_VEC]),
      .prev_i(prev_w[v*PINS_PER_VEC +: PINS_PER_VEC]),
      .en_i  (pin_irq_en_i[v*PINS_PER_VEC +: PINS_PER_VEC]),
      .mode_i(sens_e'(sens_q[2*v +: 2])),
      .hit_o (hit_w[v])
    );

    eirq_latch u_lat (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .hit_i (hit_w[v]),
      .ack_i (vec_ack_i[v]),
      .drop_i(drop_w[v]),
      .req_o (irq_o[v])
    );
  end
endmodule

// File: rtl/eirq_unit_chk.sv
module eirq_unit_chk #(
  parameter int NV = 2,
  parameter int PP = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [NV-1:0]    irq,
  input logic [NV-1:0]    ack,
  input logic [NV-1:0]    hit,
  input logic [NV-1:0]    drop,
  input logic [NV*PP-1:0] en
);
  for (genvar v = 0; v < NV; v++) begin : g_chk
    p_disabled_r2: assert property (@(posedge clk) disable iff (rst)
      (en[v*PP +: PP] == '0) |-> !hit[v]);
    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
      (!irq[v] && !hit[v]) |=> !irq[v]);
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (irq[v] && !ack[v] && !drop[v]) |=> irq[v]);
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (rst)
      (irq[v] && ack[v] && !hit[v] && !drop[v]) |=> !irq[v]);
    p_event_wins_r9: assert property (@(posedge clk) disable iff (rst)
      (hit[v] && !drop[v]) |=> irq[v]);
    p_rewrite_clears_r10: assert property (@(posedge clk) disable iff (rst)
      drop[v] |=> !irq[v]);
  end
endmodule

bind eirq_unit eirq_unit_chk #(.NV(NUM_VEC), .PP(PINS_PER_VEC)) u_chk (
  .clk (clk_i),
  .rst (rst_i),
  .irq (irq_o),
  .ack (vec_ack_i),
  .hit (hit_w),
  .drop(drop_w),
  .en  (pin_irq_en_i)
);

// File: tb/eirq_unit_test.sv
`timescale 1ns/1ps
module eirq_unit_test;
  localparam int NV = 2;
  localparam int PP = 4;

  logic             clk = 1'b0;
  logic             rst;
  logic [NV*PP-1:0] pins, en;
  logic             swe;
  logic [2*NV-1:0]  swd;
  logic [NV-1:0]    ack;
  logic [NV-1:0]    irq;

  eirq_unit #(.NUM_VEC(NV), .PINS_PER_VEC(PP)) uut (
    .clk_i(clk), .rst_i(rst), .pin_i(pins), .pin_irq_en_i(en),
    .sens_we_i(swe), .sens_wdata_i(swd), .vec_ack_i(ack), .irq_o(irq)
  );

  always #5 clk = ~clk;

  typedef struct {
    int          cyc;
    logic [NV-1:0] val;
    string       req;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    total = 0;
  int    fails = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops due expectations and compares, clear of the edges.
  always @(negedge clk) begin
    #1;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      item_t it;
      it = q.pop_front();
      total++;
      if (it.cyc != cyc || irq !== it.val) begin
        fails++;
        $display("FAIL %s: irq=%b expected=%b (cycle %0d, due %0d)",
                 it.req, irq, it.val, cyc, it.cyc);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_at(input int d, input logic [NV-1:0] v, input string r);
    item_t it;
    it.cyc = cyc + d;
    it.val = v;
    it.req = r;
    q.push_back(it);
  endtask

  task automatic write_sens(input logic [2*NV-1:0] v);
    swe = 1'b1; swd = v;
    tick(1);
    swe = 1'b0;
  endtask

  task automatic pulse_ack(input logic [NV-1:0] a);
    ack = a;
    tick(1);
    ack = '0;
  endtask

  initial begin
    rst = 1'b1; pins = '1; en = '0; swe = 1'b0; swd = '0; ack = '0;
    tick(3);
    rst = 1'b0;
    expect_at(0, 2'b00, "R1");
    tick(2);

    // R2: disabled pin low in level mode never requests
    pins[0] = 1'b0;
    expect_at(3, 2'b00, "R2"); expect_at(5, 2'b00, "R2");
    tick(6);
    pins[0] = 1'b1;
    tick(4);

    // R3: rising only on both vectors
    write_sens(4'b01_01);
    en = '1;
    tick(3);
    expect_at(0, 2'b00, "R3");
    pins[1] = 1'b0;
    expect_at(3, 2'b00, "R3"); expect_at(4, 2'b00, "R3");
    tick(5);
    pins[1] = 1'b1;
    expect_at(2, 2'b00, "R11"); expect_at(3, 2'b01, "R11");
    tick(5);
    expect_at(0, 2'b01, "R8");
    pulse_ack(2'b01);
    expect_at(0, 2'b00, "R8");
    tick(2);

    // R7: group 1 pin, plus two group-0 pins together
    pins[6] = 1'b0;
    expect_at(4, 2'b00, "R7");
    tick(5);
    pins[6] = 1'b1;
    expect_at(3, 2'b10, "R7");
    tick(4);
    pulse_ack(2'b10);
    expect_at(0, 2'b00, "R7");
    pins[3:2] = 2'b00;
    tick(4);
    pins[3:2] = 2'b11;
    expect_at(3, 2'b01, "R7");
    tick(4);
    pulse_ack(2'b01);
    expect_at(0, 2'b00, "R8");
    tick(2);

    // R5: both edges on vector 0
    write_sens(4'b01_11);
    expect_at(0, 2'b00, "R5");
    pins[0] = 1'b0;
    expect_at(3, 2'b01, "R5");
    tick(4);
    pulse_ack(2'b01);
    expect_at(0, 2'b00, "R5");
    tick(1);
    // R9: rising edge detected in the same cycle as acknowledge
    pins[0] = 1'b1;
    tick(2);
    pulse_ack(2'b01);
    expect_at(0, 2'b01, "R9"); expect_at(1, 2'b01, "R9");
    tick(2);
    pulse_ack(2'b01);
    expect_at(0, 2'b00, "R8");
    tick(2);

    // R4: falling only
    write_sens(4'b01_10);
    pins[0] = 1'b0;
    expect_at(3, 2'b01, "R4");
    tick(4);
    pulse_ack(2'b01);
    tick(1);
    pins[0] = 1'b1;
    expect_at(3, 2'b00, "R4"); expect_at(5, 2'b00, "R4");
    tick(6);

    // R10: same-value write keeps, changed write drops
    pins[0] = 1'b0;
    expect_at(3, 2'b01, "R10");
    tick(4);
    write_sens(4'b01_10);
    expect_at(0, 2'b01, "R10"); expect_at(2, 2'b01, "R10");
    tick(3);
    write_sens(4'b01_01);
    expect_at(0, 2'b00, "R10"); expect_at(3, 2'b00, "R10");
    tick(4);

    // R6: level mode with pin0 still low
    write_sens(4'b01_00);
    expect_at(0, 2'b00, "R10"); expect_at(1, 2'b01, "R6");
    tick(3);
    pulse_ack(2'b01);
    expect_at(0, 2'b01, "R6"); expect_at(2, 2'b01, "R6");
    tick(3);
    pins[0] = 1'b1;
    tick(4);
    expect_at(0, 2'b01, "R6");
    pulse_ack(2'b01);
    expect_at(0, 2'b00, "R6"); expect_at(3, 2'b00, "R6");
    tick(5);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule